// File: doc/BRIEF.md
# Low-speed USB packet receiver

This block turns an oversampled, already synchronized D+/D- line pair into the data bytes of one low-speed USB packet. An internal phase tracker picks one sample point per bit time and moves it back to the bit centre whenever the line changes. The block then hunts for the sync pattern and takes byte alignment from the two K bit times that end it. From there it decodes the NRZI line states, drops stuff bits and assembles bytes least significant bit first.

Each completed data byte goes out through a plain write port made of a strobe, an address and the data. The sync byte itself is never written. The first data byte of every packet lands at address 0, and the address steps by one for each byte after that. An SE0 on the line ends the packet with a one-cycle done pulse. A packet that holds more bytes than the buffer can take is dropped and reported as an overflow instead. A sync hunt that stalls raises a sync error. CRC and PID checks are left to the logic that reads the buffer.

Top module: `usb_ls_rx`

## Requirements
- R1: During and immediately after reset, wr_en, pkt_done, overflow and sync_err are all 0.
- R2: Line encoding is {line_dp,line_dm}: J = 01 (idle), K = 10, SE0 = 00. Starting from idle, the block locks on the first two consecutive K bit times that follow a K. The sync byte is not written, and the first written byte is the first byte after the sync.
- R3: A bit time whose sampled state equals the previous one decodes as 1, and a change of state decodes as 0. Bits fill each byte from bit 0 up to bit 7, and the byte appears on wr_data with a wr_en pulse once its eighth bit is decoded.
- R4: After six decoded 1s in a row, the next bit time is a stuff bit. It updates the previous-state reference but is not a data bit. This also holds when the run of 1s crosses a byte boundary.
- R5: Within a packet, written bytes carry wr_addr 0, 1, 2 and so on in arrival order.
- R6: An SE0 sample during data ends the packet with a single-cycle pkt_done pulse, provided no overflow occurred.
- R7: A packet of exactly BUF_BYTES bytes completes normally. When byte number BUF_BYTES+1 arrives, overflow pulses once, nothing more is written, pkt_done is not raised for that packet, and the next packet is received normally.
- R8: While hunting for sync, SYNC_GAP_BITS consecutive bit times without K (or an SE0) raise a one-cycle sync_err and return the block to idle without writing anything.
- R9: A K followed by J during the hunt does not lock, and hunting continues, so any number of extra K/J pairs before the final K K still gives a correct lock.
- R10: The sample point is re-centred on every line transition, so packets decode correctly whatever clock phase they start on relative to earlier traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, OSR cycles per bit time |
| rst_n | input | 1 | Active-low synchronous reset |
| line_dp | input | 1 | Synchronized D+ level |
| line_dm | input | 1 | Synchronized D- level |
| wr_en | output | 1 | Buffer write strobe, one cycle per byte |
| wr_addr | output | ADDR_W | Buffer address of the byte being written |
| wr_data | output | 8 | Received byte |
| pkt_done | output | 1 | One-cycle pulse at a clean end of packet |
| overflow | output | 1 | One-cycle pulse when the packet exceeds the buffer |
| sync_err | output | 1 | One-cycle pulse when the sync hunt times out |

## Verification
The bench builds the block with OSR=4, BUF_BYTES=4 and SYNC_GAP_BITS=3. The small buffer means the exact-fit and one-byte-over packets, and a clean packet sent after an overflow, take only a few bytes each. The short gap limit lets a broken sync trip the error after three idle bit times. Four clocks per bit keep each packet short while still leaving a clear centre sample, so a packet that starts one clock off the previous phase exercises the re-centring.

// File: rtl/usb_ls_rx_pkg.sv
package usb_ls_rx_pkg;

  // {dp,dm} line states
  typedef enum logic [1:0] {
    LN_SE0 = 2'b00,
    LN_J   = 2'b01,
    LN_K   = 2'b10,
    LN_SE1 = 2'b11
  } line_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SYNC,
    ST_DATA,
    ST_DROP
  } rx_state_t;

  localparam int BYTE_W    = 8;
  localparam int BITIDX_W  = $clog2(BYTE_W);
  localparam int STUFF_RUN = 6;
  localparam int RUN_W     = $clog2(STUFF_RUN + 1);

  // NRZI: unchanged state is a one, any change is a zero
  function automatic logic nrzi_bit(input line_t prev, input line_t cur);
    return prev == cur;
  endfunction

  function automatic logic stuff_due(input logic [RUN_W-1:0] ones);
    return ones == RUN_W'(STUFF_RUN);
  endfunction

  // next run length of consecutive ones
  function automatic logic [RUN_W-1:0] next_run(input logic [RUN_W-1:0] ones, input logic b);
    return b ? ones + RUN_W'(1) : '0;
  endfunction

endpackage

// File: rtl/usb_ls_rx_phase.sv
module usb_ls_rx_phase
  import usb_ls_rx_pkg::*;
#(
  parameter int OSR = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  line_t line,
  output logic  samp_en
);
  localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  line_t         prev_line;
  logic [CW-1:0] phase;
  logic          line_edge;

  assign line_edge = (line != prev_line);
  assign samp_en   = (phase == MID) && !line_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_line <= LN_J;
      phase     <= '0;
    end else begin
      prev_line <= line;
      if (line_edge)          phase <= '0;
      else if (phase == LAST) phase <= '0;
      else                    phase <= phase + CW'(1);
    end
  end

  // R10: at most one sample point per bit window
  a_r10_single_sample: assert property (@(posedge clk) disable iff (!rst_n)
    samp_en |=> !samp_en);

endmodule

// File: rtl/usb_ls_rx_sync.sv
module usb_ls_rx_sync
  import usb_ls_rx_pkg::*;
#(
  parameter int GAP_BITS = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  samp_en,
  input  logic  hunt,
  input  line_t line,
  output logic  lock,
  output logic  fail
);
  localparam int GW = $clog2(GAP_BITS + 1);

  logic          last_k;
  logic [GW-1:0] gap;
  logic          step;
  logic          is_k;

  assign step = samp_en && hunt;
  assign is_k = (line == LN_K);
  assign lock = step && is_k && last_k;
  assign fail = step && ((line == LN_SE0) || (!is_k && gap == GW'(GAP_BITS - 1)));

  always_ff @(posedge clk) begin
    if (!rst_n || !hunt) begin
      last_k <= 1'b1;   // the hunt is entered on a K sample
      gap    <= '0;
    end else if (step) begin
      last_k <= is_k;
      gap    <= is_k ? '0 : gap + GW'(1);
    end
  end

  // R8 / R2: lock and timeout never coincide
  a_r8_lock_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock && fail));

endmodule

// File: rtl/usb_ls_rx_decode.sv
module usb_ls_rx_decode
  import usb_ls_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_en,
  input  logic              run,
  input  line_t             line,
  output logic              byte_stb,
  output logic [BYTE_W-1:0] byte_val
);
  line_t               prev;
  logic [RUN_W-1:0]    ones;
  logic [BITIDX_W-1:0] nbit;
  logic [BYTE_W-1:0]   shreg;
  logic                step;
  logic                dbit;
  logic                stuff_evt;
  logic                data_evt;
  logic [BYTE_W-1:0]   shifted;

  assign step      = samp_en && run && (line != LN_SE0);
  assign dbit      = nrzi_bit(prev, line);
  assign stuff_evt = step && stuff_due(ones);
  assign data_evt  = step && !stuff_due(ones);
  assign shifted   = {dbit, shreg[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev     <= LN_K;
      ones     <= '0;
      nbit     <= '0;
      shreg    <= '0;
      byte_stb <= 1'b0;
      byte_val <= '0;
    end else begin
      byte_stb <= 1'b0;
      if (!run) begin
        prev <= LN_K;   // last sync bit is K
        ones <= '0;
        nbit <= '0;
      end else if (stuff_evt) begin
        prev <= line;
        ones <= '0;
      end else if (data_evt) begin
        prev  <= line;
        ones  <= next_run(ones, dbit);
        shreg <= shifted;
        nbit  <= nbit + BITIDX_W'(1);
        if (nbit == BITIDX_W'(BYTE_W - 1)) begin
          byte_stb <= 1'b1;
          byte_val <= shifted;
        end
      end
    end
  end

  // R4: run of ones never exceeds the stuffing limit
  a_r4_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= RUN_W'(STUFF_RUN));

  // R4: a stuff bit never advances the bit position
  a_r4_stuff_holds_pos: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_evt |=> $stable(nbit) && !byte_stb);

endmodule

// File: rtl/usb_ls_rx.sv
module usb_ls_rx
  import usb_ls_rx_pkg::*;
#(
  parameter  int OSR           = 4,
  parameter  int BUF_BYTES     = 8,
  parameter  int SYNC_GAP_BITS = 3,
  localparam int ADDR_W        = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_dp,
  input  logic              line_dm,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              pkt_done,
  output logic              overflow,
  output logic              sync_err
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);

  line_t             line;
  rx_state_t         state;
  logic [CNT_W-1:0]  count;
  logic              samp_en;
  logic              sync_lock;
  logic              sync_fail;
  logic              byte_stb;
  logic [BYTE_W-1:0] byte_val;
  logic              se0_seen;
  logic              buf_full;

  assign line     = line_t'({line_dp, line_dm});
  assign se0_seen = samp_en && (line == LN_SE0);
  assign buf_full = (count == CNT_W'(BUF_BYTES));

  usb_ls_rx_phase #(.OSR(OSR)) i_phase (
    .clk(clk), .rst_n(rst_n), .line(line), .samp_en(samp_en)
  );

  usb_ls_rx_sync #(.GAP_BITS(SYNC_GAP_BITS)) i_sync (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en),
    .hunt(state == ST_SYNC), .line(line),
    .lock(sync_lock), .fail(sync_fail)
  );

  usb_ls_rx_decode i_decode (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en),
    .run(state == ST_DATA), .line(line),
    .byte_stb(byte_stb), .byte_val(byte_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      count    <= '0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      pkt_done <= 1'b0;
      overflow <= 1'b0;
      sync_err <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      pkt_done <= 1'b0;
      overflow <= 1'b0;
      sync_err <= 1'b0;
      unique case (state)
        ST_IDLE: if (samp_en && line == LN_K) state <= ST_SYNC;
        ST_SYNC: begin
          if (sync_fail) begin
            sync_err <= 1'b1;
            state    <= ST_IDLE;
          end else if (sync_lock) begin
            count <= '0;
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (se0_seen) begin
            pkt_done <= 1'b1;
            state    <= ST_IDLE;
          end else if (byte_stb) begin
            if (buf_full) begin
              overflow <= 1'b1;
              state    <= ST_DROP;
            end else begin
              wr_en   <= 1'b1;
              wr_addr <= count[ADDR_W-1:0];
              wr_data <= byte_val;
              count   <= count + CNT_W'(1);
            end
          end
        end
        ST_DROP: if (se0_seen) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: writes only happen inside a locked packet
  a_r2_write_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> state == ST_DATA);

  // R5: address never leaves the buffer
  a_r5_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_addr <= ADDR_W'(BUF_BYTES - 1));

  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);

  // R7: overflow neither writes nor completes, and leads to the drop state
  a_r7_ovf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> !wr_en && !pkt_done && state == ST_DROP);

  // R8: a sync error returns to idle
  a_r8_err_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> state == ST_IDLE);

endmodule

// File: tb/test_usb_ls_rx.sv
`timescale 1ns/1ps
module test_usb_ls_rx;
  localparam int OSR = 4;
  localparam int BUF = 4;
  localparam int GAP = 3;
  localparam int AW  = 2;
  localparam logic [1:0] J = 2'b01, K = 2'b10, SE0 = 2'b00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_dp, line_dm;
  logic wr_en, pkt_done, overflow, sync_err;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;

  always #2 clk = ~clk;

  usb_ls_rx #(.OSR(OSR), .BUF_BYTES(BUF), .SYNC_GAP_BITS(GAP)) i_usb_ls_rx (
    .clk(clk), .rst_n(rst_n), .line_dp(line_dp), .line_dm(line_dm),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pkt_done(pkt_done), .overflow(overflow), .sync_err(sync_err)
  );

  int n_cmp = 0, n_bad = 0;
  int done_cnt = 0, ovf_cnt = 0, err_cnt = 0;
  bit finished = 0;
  string cur_req = "R1";
  logic [AW+7:0] exp_q[$];
  logic [7:0] pkt[16];

  task automatic check(input string req, input int act, input int exp_v);
    n_cmp++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL %s: unexpected write addr %0d data %02h expected none", cur_req, wr_addr, wr_data);
        end else begin
          logic [AW+7:0] e;
          e = exp_q.pop_front();
          check({cur_req, " R5 addr"}, int'(wr_addr), int'(e[AW+7:8]));
          check({cur_req, " R3 data"}, int'(wr_data), int'(e[7:0]));
        end
      end
      if (pkt_done) done_cnt++;
      if (overflow) ovf_cnt++;
      if (sync_err) err_cnt++;
    end
  end

  task automatic hold(input logic [1:0] st, input int clocks);
    {line_dp, line_dm} = st;
    repeat (clocks) @(posedge clk);
    #1;
  endtask

  task automatic bit_time(input logic [1:0] st);
    hold(st, OSR);
  endtask

  // bench-side encoder: sync, NRZI with stuffing, EOP
  task automatic send_pkt(input int n, input int extra_pairs);
    logic [1:0] st;
    int ones;
    for (int p = 0; p < extra_pairs; p++) begin bit_time(K); bit_time(J); end
    for (int s = 0; s < 3; s++) begin bit_time(K); bit_time(J); end
    bit_time(K); bit_time(K);
    st = K; ones = 0;
    for (int i = 0; i < n; i++) begin
      if (i < BUF) exp_q.push_back({AW'(i), pkt[i]});
      for (int b = 0; b < 8; b++) begin
        if (pkt[i][b]) ones++;
        else begin st = ~st; ones = 0; end
        bit_time(st);
        if (ones == 6) begin st = ~st; ones = 0; bit_time(st); end
      end
    end
    bit_time(SE0); bit_time(SE0);
    for (int q = 0; q < 4; q++) bit_time(J);
  endtask

  task automatic expect_end(input string req, input int d, input int o, input int e);
    check({req, " done count"}, done_cnt, d);
    check({req, " overflow count"}, ovf_cnt, o);
    check({req, " sync_err count"}, err_cnt, e);
    check({req, " missing writes"}, exp_q.size(), 0);
    done_cnt = 0; ovf_cnt = 0; err_cnt = 0;
    exp_q.delete();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    {line_dp, line_dm} = J;
    repeat (5) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 wr_en", int'(wr_en), 0);
    check("R1 pkt_done", int'(pkt_done), 0);
    rst_n = 1'b1;
    hold(J, 1);
    check("R1 overflow", int'(overflow), 0);
    check("R1 sync_err", int'(sync_err), 0);
    for (int q = 0; q < 4; q++) bit_time(J);

    // R2 R3 R5 R6: basic packet
    cur_req = "R2/R3";
    pkt[0] = 8'hA5; pkt[1] = 8'h3C;
    send_pkt(2, 0);
    expect_end("R6 basic", 1, 0, 0);

    // R4: stuffing, including a run crossing byte boundaries
    cur_req = "R4";
    pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h7E;
    send_pkt(3, 0);
    expect_end("R4 stuffed", 1, 0, 0);

    // R7: exact fit
    cur_req = "R7 fit";
    pkt[0] = 8'h00; pkt[1] = 8'h80; pkt[2] = 8'h01; pkt[3] = 8'hC3;
    send_pkt(4, 0);
    expect_end("R7 fit", 1, 0, 0);

    // R7: one byte too many
    cur_req = "R7 over";
    pkt[0] = 8'h11; pkt[1] = 8'h22; pkt[2] = 8'h33; pkt[3] = 8'h44; pkt[4] = 8'h55;
    send_pkt(5, 0);
    expect_end("R7 over", 0, 1, 0);

    // R7: recovery after overflow
    cur_req = "R7 recover";
    pkt[0] = 8'h5A;
    send_pkt(1, 0);
    expect_end("R7 recover", 1, 0, 0);

    // R8: stalled sync
    cur_req = "R8";
    bit_time(K);
    for (int q = 0; q < 6; q++) bit_time(J);
    expect_end("R8 timeout", 0, 0, 1);

    // R9 R10: long alternating prefix, started one clock off phase
    cur_req = "R9/R10";
    hold(J, 1);
    pkt[0] = 8'h12; pkt[1] = 8'hF0;
    send_pkt(2, 3);
    expect_end("R9 R10 prefix+phase", 1, 0, 0);

    finish_run();
  end
endmodule